// File: doc/BRIEF.md
# Four-Channel Shadowed Pulse-Width Modulator

This block drives four independent pulse-width-modulated outputs. Software reaches it through a simple word-addressed register bus. Each channel has three registers:

- a 16-bit period count;
- a 16-bit high-time (duty) count;
- a control word that picks a power-of-two prescale of a shared 1 MHz tick enable and an output inversion.

Writes to the duty and control registers only change the values software sees. A period write arms the channel. The whole new set (period, duty, prescale, inversion) then replaces the running set at the next period boundary, so no cycle is ever produced with half old and half new settings.

A period of zero is a graceful stop. The running period finishes, and after that the output stays low whatever the inversion setting. An idle channel that is given a nonzero period starts at the next 1 MHz tick and counts from zero.

Top module: `pwm_shadow_top`

## Requirements
- R1: After reset every output is low and every mapped register reads zero.
- R2: Registers for channel c (0..3) are at byte addresses 0x400+4c (period, bits [15:0]), 0x420+4c (duty, bits [15:0]) and 0x440+4c (control: bits [1:0] prescale select, bit 5 invert). A read returns the last written value and reads zero in unused control bits.
- R3: Any address that is not word aligned, that names a channel index of 4 or more, or that lies outside the three banks reads as zero, and a write to it changes no register.
- R4: With prescale select n, the channel counter advances only on the 1 MHz ticks whose index since reset (counting from 0) is a multiple of 2^n.
- R5: While running with period P, the counter steps through 0..P-1 and the non-inverted output is high exactly while the counter is below the duty value. A duty of 0 gives constant low, and a duty of P or more gives constant high.
- R6: Control bit 5 set inverts the output of a running channel.
- R7: Duty and control writes without a following period write never change the waveform being produced.
- R8: After a period write, the running channel loads the latest period, duty and control values on the counting tick where the counter is at P-1, and restarts from zero.
- R9: A channel whose active period is zero loads a pending setting on the next 1 MHz tick.
- R10: Loading a period of zero stops the channel, and its output stays low for both polarities.
- R11: The four channels operate independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle 1 MHz tick enable |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational, valid while req_i is high and we_i is low |
| pwm_o | output | 4 | Channel outputs, bit c is channel c |

## Verification
The case that matters most is a period write that lands in the same clock cycle as the boundary load. In that cycle the old shadow set must be committed and the channel must stay armed for the new value. The random phase issues dense period, duty and control writes with short periods and all four prescales, so writes regularly fall on a boundary tick. A cycle-accurate model in the bench, built from the requirements, predicts every output bit in every cycle and judges the result.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int NCH  = 4;
  localparam int CW   = 16;
  localparam int AW   = 12;
  localparam int DW   = 16;
  localparam int DIVW = 2;
  localparam int NDIV = 1 << DIVW;
  localparam int INV_BIT = 5;
  localparam logic [AW-1:0] BASE_PER  = 12'h400;
  localparam logic [AW-1:0] BASE_DUTY = 12'h420;
  localparam logic [AW-1:0] BASE_CTRL = 12'h440;
  typedef enum logic [1:0] {K_NONE, K_PER, K_DUTY, K_CTRL} reg_kind_e;
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [DW-1:0]            rdata_o,
  output logic [NCH-1:0][CW-1:0]   per_q_o,
  output logic [NCH-1:0][CW-1:0]   duty_q_o,
  output logic [NCH-1:0][DIVW-1:0] div_q_o,
  output logic [NCH-1:0]           inv_q_o,
  output logic [NCH-1:0]           per_wr_o
);
  reg_kind_e  kind;
  logic [2:0] ch;

  always_comb begin
    ch   = addr_i[4:2];
    kind = K_NONE;
    if (addr_i[1:0] == 2'b00 && int'(ch) < NCH) begin
      if (addr_i[AW-1:5] == BASE_PER[AW-1:5])       kind = K_PER;
      else if (addr_i[AW-1:5] == BASE_DUTY[AW-1:5]) kind = K_DUTY;
      else if (addr_i[AW-1:5] == BASE_CTRL[AW-1:5]) kind = K_CTRL;
    end
  end

  wire wr = req_i && we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q_o  <= '0;
      duty_q_o <= '0;
      div_q_o  <= '0;
      inv_q_o  <= '0;
    end else if (wr) begin
      for (int i = 0; i < NCH; i++) begin
        if (int'(ch) == i) begin
          case (kind)
            K_PER:  per_q_o[i]  <= wdata_i[CW-1:0];
            K_DUTY: duty_q_o[i] <= wdata_i[CW-1:0];
            K_CTRL: begin
              div_q_o[i] <= wdata_i[DIVW-1:0];
              inv_q_o[i] <= wdata_i[INV_BIT];
            end
            default: ;
          endcase
        end
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_wr
    assign per_wr_o[g] = wr && kind == K_PER && int'(ch) == g;
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      case (kind)
        K_PER:  rdata_o = per_q_o[ch[1:0]];
        K_DUTY: rdata_o = duty_q_o[ch[1:0]];
        K_CTRL: begin
          rdata_o[DIVW-1:0] = div_q_o[ch[1:0]];
          rdata_o[INV_BIT]  = inv_q_o[ch[1:0]];
        end
        default: ;
      endcase
    end
  end

  AST_UNMAPPED_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && kind == K_NONE) |=> ($stable(per_q_o) && $stable(duty_q_o) && $stable(div_q_o) && $stable(inv_q_o))); // R3
  AST_ONE_PER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(per_wr_o)); // R11
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  output logic [NDIV-1:0] stb_o
);
  localparam int PW = NDIV - 1;
  logic [PW-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (tick_i) pre_q <= pre_q + 1'b1;
  end

  for (genvar k = 0; k < NDIV; k++) begin : g_stb
    localparam logic [PW-1:0] MASK = PW'((1 << k) - 1);
    assign stb_o[k] = tick_i && ((pre_q & MASK) == '0);
  end

  for (genvar k = 1; k < NDIV; k++) begin : g_nest
    AST_STB_NESTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stb_o[k] |-> stb_o[k-1]); // R4
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [NDIV-1:0] stb_i,
  input  logic            per_wr_i,
  input  logic [CW-1:0]   per_sh_i,
  input  logic [CW-1:0]   duty_sh_i,
  input  logic [DIVW-1:0] div_sh_i,
  input  logic            inv_sh_i,
  output logic            pwm_o
);
  logic [CW-1:0]   per_q, duty_q, cnt_q;
  logic [DIVW-1:0] div_q;
  logic            inv_q, pend_q;

  wire running  = per_q != '0;
  wire cnt_tick = running && stb_i[div_q];
  wire at_end   = cnt_q == per_q - CW'(1);
  wire load     = pend_q && (running ? (cnt_tick && at_end) : tick_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q  <= '0;
      duty_q <= '0;
      cnt_q  <= '0;
      div_q  <= '0;
      inv_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (load) begin
        per_q  <= per_sh_i;
        duty_q <= duty_sh_i;
        div_q  <= div_sh_i;
        inv_q  <= inv_sh_i;
        cnt_q  <= '0;
      end else if (cnt_tick) begin
        cnt_q <= at_end ? '0 : cnt_q + 1'b1;
      end
      // a period write in the load cycle re-arms for the next boundary
      if (per_wr_i)  pend_q <= 1'b1;
      else if (load) pend_q <= 1'b0;
    end
  end

  assign pwm_o = running && ((cnt_q < duty_q) ^ inv_q);

  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_q == '0) |-> !pwm_o); // R10
  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_q != '0) |-> (cnt_q < per_q)); // R5
  AST_HOLD_MIDPERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_q != '0 && cnt_q != per_q - CW'(1)) |=> ($stable(duty_q) && $stable(inv_q) && $stable(div_q))); // R7
  AST_NO_LOAD_UNARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_q |=> ($stable(per_q) && $stable(duty_q))); // R8
endmodule

// File: rtl/pwm_shadow_top.sv
module pwm_shadow_top
  import pwm_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic           req_i,
  input  logic           we_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  output logic [NCH-1:0] pwm_o
);
  logic [NCH-1:0][CW-1:0]   per_q, duty_q;
  logic [NCH-1:0][DIVW-1:0] div_q;
  logic [NCH-1:0]           inv_q, per_wr;
  logic [NDIV-1:0]          stb;

  pwm_regfile u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .per_q_o(per_q), .duty_q_o(duty_q), .div_q_o(div_q),
    .inv_q_o(inv_q), .per_wr_o(per_wr)
  );

  pwm_prescaler u_pre (.clk_i, .rst_ni, .tick_i, .stb_o(stb));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwm_channel u_ch (
      .clk_i, .rst_ni, .tick_i,
      .stb_i(stb),
      .per_wr_i(per_wr[c]),
      .per_sh_i(per_q[c]),
      .duty_sh_i(duty_q[c]),
      .div_sh_i(div_q[c]),
      .inv_sh_i(inv_q[c]),
      .pwm_o(pwm_o[c])
    );
  end
endmodule

// File: tb/pwm_shadow_top_tb_top.sv
module pwm_shadow_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [3:0]  pwm;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_shadow_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  // 1 MHz tick stand-in: one cycle every TICK_DIV clocks
  int tcnt = 0;
  always @(negedge clk) begin
    tcnt <= (tcnt == TICK_DIV-1) ? 0 : tcnt + 1;
    tick <= (tcnt == TICK_DIV-1);
  end

  // ---------------- reference model ----------------
  logic [15:0] m_per[4], m_duty[4];
  logic [1:0]  m_div[4];
  logic        m_inv[4], m_pend[4];
  logic [15:0] a_per[4], a_duty[4], a_cnt[4];
  logic [1:0]  a_div[4];
  logic        a_inv[4];
  int          m_tk;

  // returns kind*8+ch, kind 0 period 1 duty 2 control; -1 unmapped (R2, R3)
  function automatic int decode(logic [11:0] a);
    int c;
    if (a[1:0] != 2'b00) return -1;
    c = int'(a[4:2]);
    if (c >= 4) return -1;
    case (a[11:5])
      7'h20: return c;
      7'h21: return 8 + c;
      7'h22: return 16 + c;
      default: return -1;
    endcase
  endfunction

  function automatic logic exp_pwm(int c);
    if (a_per[c] == 16'd0) return 1'b0;
    return (a_cnt[c] < a_duty[c]) ^ a_inv[c];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tk <= 0;
      for (int c = 0; c < 4; c++) begin
        m_per[c] <= '0; m_duty[c] <= '0; m_div[c] <= '0; m_inv[c] <= 1'b0;
        m_pend[c] <= 1'b0; a_per[c] <= '0; a_duty[c] <= '0; a_cnt[c] <= '0;
        a_div[c] <= '0; a_inv[c] <= 1'b0;
      end
    end else begin
      int d;
      d = (req && we) ? decode(addr) : -1;
      if (tick) m_tk <= m_tk + 1;
      for (int c = 0; c < 4; c++) begin
        logic ct, ld;
        ct = 1'b0;
        if (a_per[c] == 16'd0) ld = tick && m_pend[c];
        else begin
          ct = tick && ((m_tk % (1 << a_div[c])) == 0);
          ld = ct && (a_cnt[c] == a_per[c] - 16'd1) && m_pend[c];
        end
        if (ld) begin
          a_per[c] <= m_per[c]; a_duty[c] <= m_duty[c];
          a_div[c] <= m_div[c]; a_inv[c] <= m_inv[c];
          a_cnt[c] <= '0; m_pend[c] <= 1'b0;
        end else if (ct) begin
          a_cnt[c] <= (a_cnt[c] == a_per[c] - 16'd1) ? 16'd0 : a_cnt[c] + 16'd1;
        end
        if (d == c)      begin m_per[c] <= wdata; m_pend[c] <= 1'b1; end
        if (d == 8 + c)  m_duty[c] <= wdata;
        if (d == 16 + c) begin m_div[c] <= wdata[1:0]; m_inv[c] <= wdata[5]; end
      end
    end
  end

  // ---------------- checking ----------------
  task automatic check(string req_tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %0h exp %0h at %0t", req_tag, got, exp, $time);
    end
  endtask

  // per-cycle waveform comparison, covers R4 R5 R6 R8 R9 R10 R11
  bit run_chk = 1'b0;
  always @(negedge clk) begin
    if (run_chk && !done) begin
      for (int c = 0; c < 4; c++) begin
        checks++;
        if (pwm[c] !== exp_pwm(c)) begin
          fails++;
          $display("FAIL R5 ch%0d pwm got %b exp %b at %0t", c, pwm[c], exp_pwm(c), $time);
        end
      end
    end
  end

  bit [3:0] seen_high = '0;
  always @(negedge clk) seen_high <= seen_high | pwm;

  task automatic bus_wr(logic [11:0] a, logic [15:0] v);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = v;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(string req_tag, logic [11:0] a, logic [15:0] exp);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 check(req_tag, rdata, exp);
    @(negedge clk);
    req = 1'b0;
  endtask

  function automatic logic [15:0] model_rd(logic [11:0] a);
    int d;
    d = decode(a);
    if (d < 0) return 16'h0;
    if (d < 8)  return m_per[d];
    if (d < 16) return m_duty[d-8];
    return {10'd0, m_inv[d-16], 3'd0, m_div[d-16]};
  endfunction

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_2024));
    wait_cyc(3);
    #1;
    check("R1", {28'd0, pwm}, 32'd0);
    rst_n = 1'b1;
    wait_cyc(2);
    check("R1", {28'd0, pwm}, 32'd0);
    for (int c = 0; c < 4; c++) begin
      bus_rd("R1", 12'h400 + 12'(4*c), 16'h0);
      bus_rd("R1", 12'h440 + 12'(4*c), 16'h0);
    end
    run_chk = 1'b1;

    // R2: readback and control masking
    bus_wr(12'h424, 16'hBEEF);
    bus_rd("R2", 12'h424, 16'hBEEF);
    bus_wr(12'h44C, 16'hFFFF);
    bus_rd("R2", 12'h44C, 16'h0023);
    bus_wr(12'h44C, 16'h0000);

    // R3: unmapped addresses
    bus_wr(12'h410, 16'h1234);
    bus_wr(12'h402, 16'h5678);
    bus_wr(12'h460, 16'h9ABC);
    bus_rd("R3", 12'h410, 16'h0);
    bus_rd("R3", 12'h402, 16'h0);
    bus_rd("R3", 12'h460, 16'h0);
    bus_rd("R3", 12'h400, 16'h0);
    check("R3", {28'd0, pwm}, 32'd0);

    // R9 + R5: idle channel 1 starts, duty 2 of period 4, divide by 1
    bus_wr(12'h424, 16'd2);
    bus_wr(12'h404, 16'd4);
    wait_cyc(60);
    // R7: duty change alone keeps producing highs
    bus_wr(12'h424, 16'd0);
    seen_high = '0;
    wait_cyc(80);
    check("R7", {31'd0, seen_high[1]}, 32'd1);
    // R8: commit via period write -> duty 0 -> constant low afterwards
    bus_wr(12'h404, 16'd4);
    wait_cyc(40);
    seen_high = '0;
    wait_cyc(40);
    check("R8", {31'd0, seen_high[1]}, 32'd0);

    // R6 + R4: channel 2 inverted, divide by 8, duty >= period
    bus_wr(12'h448, 16'h0023);
    bus_wr(12'h428, 16'd9);
    bus_wr(12'h408, 16'd3);
    wait_cyc(300);
    // R10: stop with inversion set, output must stay low
    bus_wr(12'h408, 16'd0);
    wait_cyc(200);
    seen_high = '0;
    wait_cyc(100);
    check("R10", {31'd0, seen_high[2]}, 32'd0);

    // R11 + random mix against the model
    for (int i = 0; i < 3000; i++) begin
      int c, op;
      logic [11:0] a;
      c  = int'($urandom_range(0, 3));
      op = int'($urandom_range(0, 9));
      case (op)
        0, 1: bus_wr(12'h400 + 12'(4*c), ($urandom_range(0, 7) == 0) ? 16'd0 : 16'($urandom_range(1, 20)));
        2, 3: bus_wr(12'h420 + 12'(4*c), 16'($urandom_range(0, 22)));
        4:    bus_wr(12'h440 + 12'(4*c), 16'($urandom));
        5, 6: begin
          a = 12'h400 + 12'($urandom_range(0, 23) * 4);
          bus_rd("R11", a, model_rd(a));
        end
        7:    begin
          a = 12'($urandom);
          bus_rd("R3", a, model_rd(a));
        end
        default: wait_cyc(int'($urandom_range(0, 30)));
      endcase
    end
    wait_cyc(50);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule